// File: doc/BRIEF.md
# Parallel LCD Bus Timing Engine

This block sits on the host side of an 8-bit parallel character-display bus and carries out one bus transaction per request. A requester presents a register-select bit, a read/write bit, a data byte and a mode bit. The engine latches them, drives the select and direction lines, raises and lowers the enable strobe, and either drives the data byte or samples the byte the display returns. Every phase of the strobe is a whole number of clock cycles. Each length is the ceiling of a nanosecond limit divided by the `CLK_PERIOD_NS` parameter, and it is never less than one cycle.

In nibble mode the byte travels as two complete enable cycles on data lines 7..4. The high nibble goes first and the low nibble second. Lines 3..0 are driven to zero in this mode. On a nibble-mode read, the first strobe supplies the upper half of the result and the second strobe supplies the lower half. The pads are controlled by one output-enable signal. It is asserted only for writes, from address setup until the data hold time has passed after enable falls.

The controller has six states. IDLE accepts a request (IDLE->SETUP). SETUP holds the address before enable rises (SETUP->EHIGH when its timer expires). EHIGH keeps enable high and samples read data in its last cycle (EHIGH->HOLD). HOLD keeps address and data after enable falls (HOLD->RECOV). RECOV pads the enable cycle out to its minimum period. From RECOV the controller goes to SETUP if the second nibble is still due, and to DONE otherwise. DONE lasts one cycle (DONE->IDLE).

Top module: `lcd_bus_engine`

## Requirements
- R1: After reset, lcd_e, lcd_db_oe, busy and done are 0 and rd_data is 0x00.
- R2: A request is accepted only when busy is 0, and busy is 1 in the cycle after acceptance. A request presented while busy is 1 has no effect on the strobes, the address lines or the data of the transaction in progress.
- R3: With req_nibble_mode=0 a transaction gives exactly one enable pulse. lcd_rs and lcd_rw equal req_rs and req_rw (rw=1 means read), and a write drives the whole byte on lcd_db_out[7:0].
- R4: With req_nibble_mode=1 a transaction gives exactly two enable pulses. On a write, lcd_db_out[7:4] carries data[7:4] during the first pulse and data[3:0] during the second, and lcd_db_out[3:0] is 0.
- R5: Each enable pulse is high for max(ceil(140/T), ceil(40/T), ceil(190/T)) cycles, where T is CLK_PERIOD_NS. This is 19 cycles at the default 10 ns.
- R6: Successive enable rises, within a transaction and across back-to-back transactions, are at least ceil(1200/T) = 120 cycles apart.
- R7: lcd_rs and lcd_rw are valid at least ceil(10/T) cycles before enable rises. They stay unchanged while enable is high and until the next request is accepted.
- R8: On writes, lcd_db_oe is 1 and lcd_db_out is valid before enable rises. Both stay unchanged through the pulse and for max(ceil(20/T), ceil(20/T)) = 2 cycles after enable falls.
- R9: lcd_db_oe is 1 only during write transactions and is never 1 during a read.
- R10: Read data is sampled in the last enable-high cycle, no earlier than ceil(190/T) cycles after the rise. In byte mode rd_data is lcd_db_in[7:0]. In nibble mode rd_data is {lcd_db_in[7:4] of pulse 1, lcd_db_in[7:4] of pulse 2}, and lcd_db_in[3:0] is ignored.
- R11: done is a one-cycle pulse one cycle after the recovery time of the last enable cycle ends, and rd_data holds the result then. busy falls in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_rs | input | 1 | Register-select value for the transaction |
| req_rw | input | 1 | 1 = read, 0 = write |
| req_nibble_mode | input | 1 | 1 = send as two nibbles on lines 7..4 |
| req_data | input | 8 | Write byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 8 | Sampled read byte |
| lcd_rs | output | 1 | Bus register-select line |
| lcd_rw | output | 1 | Bus read/write line |
| lcd_e | output | 1 | Bus enable strobe |
| lcd_db_out | output | 8 | Data lines, driven value |
| lcd_db_oe | output | 1 | Data pad output enable |
| lcd_db_in | input | 8 | Data lines, received value |

## Verification
A state register or phase timer that goes wrong shows first on lcd_e. The pulse gets shorter than 19 cycles, or its rise comes less than 120 cycles after the previous one, and this appears within one enable period. A lost or extra nibble-sequence flag shows as a wrong pulse count or a swapped nibble on lcd_db_out[7:4] by the end of the transaction. A wrong sample strobe shows as a wrong rd_data at the done pulse. If the output enable is decoded from the wrong state, it shows as lcd_db_oe high during a read, or dropping within the two cycles after enable falls.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_EHIGH,
        ST_HOLD,
        ST_RECOV,
        ST_DONE
    } lcdb_state_t;

    // Ceiling of ns/period, never below one cycle
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcdb_phase_timer.sv
module lcdb_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R5: a phase loaded with a nonzero count cannot end in the next cycle
    p_load_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/lcdb_datapath.sv
module lcdb_datapath #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          in_rs,
    input  logic          in_rw,
    input  logic          in_nib,
    input  logic [DW-1:0] in_data,
    input  logic          advance,
    input  logic          sample,
    input  logic [DW-1:0] db_in,
    output logic          rs,
    output logic          rw,
    output logic          is4,
    output logic          second,
    output logic [DW-1:0] db_out,
    output logic [DW-1:0] rd_byte
);

    localparam int unsigned NW = DW / 2;

    logic [DW-1:0] wbyte;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs     <= 1'b0;
            rw     <= 1'b0;
            is4    <= 1'b0;
            second <= 1'b0;
            wbyte  <= '0;
        end else if (accept) begin
            rs     <= in_rs;
            rw     <= in_rw;
            is4    <= in_nib;
            second <= 1'b0;
            wbyte  <= in_data;
        end else if (advance) begin
            second <= 1'b1;
        end
    end

    // Capture: whole byte, or the upper lines into one half per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte <= '0;
        end else if (sample) begin
            if (!is4) begin
                rd_byte <= db_in;
            end else if (!second) begin
                rd_byte[DW-1:NW] <= db_in[DW-1:NW];
            end else begin
                rd_byte[NW-1:0] <= db_in[DW-1:NW];
            end
        end
    end

    always_comb begin
        if (is4) begin
            db_out = {(second ? wbyte[NW-1:0] : wbyte[DW-1:NW]), {NW{1'b0}}};
        end else begin
            db_out = wbyte;
        end
    end

    // R10: the second nibble capture keeps the first half intact
    p_keep_high_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && is4 && second) |=> (rd_byte[DW-1:NW] == $past(rd_byte[DW-1:NW])));

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
    import lcdb_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned T_CYCLE_NS    = 1200,
    parameter int unsigned T_PWH_NS      = 140,
    parameter int unsigned T_ASU_NS      = 10,
    parameter int unsigned T_AHO_NS      = 20,
    parameter int unsigned T_DSU_NS      = 40,
    parameter int unsigned T_DHO_NS      = 20,
    parameter int unsigned T_RDLY_NS     = 190
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rs,
    input  logic              req_rw,
    input  logic              req_nibble_mode,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_e,
    output logic [DATA_W-1:0] lcd_db_out,
    output logic              lcd_db_oe,
    input  logic [DATA_W-1:0] lcd_db_in
);

    localparam int unsigned SETUP_C = ns2cyc(T_ASU_NS, CLK_PERIOD_NS);
    localparam int unsigned HIGH_C  = umax(umax(ns2cyc(T_PWH_NS, CLK_PERIOD_NS),
                                                ns2cyc(T_DSU_NS, CLK_PERIOD_NS)),
                                           ns2cyc(T_RDLY_NS, CLK_PERIOD_NS));
    localparam int unsigned HOLD_C  = umax(ns2cyc(T_AHO_NS, CLK_PERIOD_NS),
                                           ns2cyc(T_DHO_NS, CLK_PERIOD_NS));
    localparam int unsigned CYC_C   = ns2cyc(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int unsigned USED_C  = SETUP_C + HIGH_C + HOLD_C;
    localparam int unsigned REC_C   = (CYC_C > USED_C) ? (CYC_C - USED_C) : 1;
    localparam int unsigned MAX_C   = umax(umax(SETUP_C, HIGH_C), umax(HOLD_C, REC_C));
    localparam int unsigned CNT_W   = $clog2(MAX_C + 1);
    localparam int unsigned MON_W   = $clog2(umax(CYC_C, HIGH_C) + 2);

    lcdb_state_t state, state_n;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic             accept, advance, sample, last_nib;
    logic             dp_rs, dp_rw, dp_is4, dp_second;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    assign last_nib = !dp_is4 || dp_second;

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_n = ST_SETUP;
            ST_SETUP: if (tmr_exp)   state_n = ST_EHIGH;
            ST_EHIGH: if (tmr_exp)   state_n = ST_HOLD;
            ST_HOLD:  if (tmr_exp)   state_n = ST_RECOV;
            ST_RECOV: if (tmr_exp)   state_n = last_nib ? ST_DONE : ST_SETUP;
            ST_DONE:                 state_n = ST_IDLE;
            default:                 state_n = ST_IDLE;
        endcase
    end

    // Phase length for the state being entered
    always_comb begin
        tmr_load = (state_n != state);
        unique case (state_n)
            ST_SETUP: tmr_val = CNT_W'(SETUP_C - 1);
            ST_EHIGH: tmr_val = CNT_W'(HIGH_C - 1);
            ST_HOLD:  tmr_val = CNT_W'(HOLD_C - 1);
            ST_RECOV: tmr_val = CNT_W'(REC_C - 1);
            default:  tmr_val = '0;
        endcase
    end

    assign accept  = (state == ST_IDLE) && req_valid;
    assign advance = (state == ST_RECOV) && tmr_exp && !last_nib;
    assign sample  = (state == ST_EHIGH) && tmr_exp && dp_rw;

    // Outputs
    always_comb begin
        lcd_e     = 1'b0;
        lcd_db_oe = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_SETUP: lcd_db_oe = !dp_rw;
            ST_EHIGH: begin
                lcd_e     = 1'b1;
                lcd_db_oe = !dp_rw;
            end
            ST_HOLD:  lcd_db_oe = !dp_rw;
            ST_RECOV: ;
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    lcdb_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    lcdb_datapath #(.DW(DATA_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .in_rs   (req_rs),
        .in_rw   (req_rw),
        .in_nib  (req_nibble_mode),
        .in_data (req_data),
        .advance (advance),
        .sample  (sample),
        .db_in   (lcd_db_in),
        .rs      (dp_rs),
        .rw      (dp_rw),
        .is4     (dp_is4),
        .second  (dp_second),
        .db_out  (lcd_db_out),
        .rd_byte (rd_data)
    );

    assign lcd_rs = dp_rs;
    assign lcd_rw = dp_rw;

    // Strobe monitors feeding the timing assertions
    logic             e_q, seen_rise;
    logic [MON_W-1:0] since_rise, hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q        <= 1'b0;
            seen_rise  <= 1'b0;
            since_rise <= '0;
            hi_cnt     <= '0;
        end else begin
            e_q <= lcd_e;
            if (lcd_e && !e_q) begin
                since_rise <= MON_W'(1);
                seen_rise  <= 1'b1;
            end else if (since_rise < MON_W'(CYC_C)) begin
                since_rise <= since_rise + 1'b1;
            end
            if (!lcd_e) begin
                hi_cnt <= '0;
            end else if (hi_cnt < MON_W'(HIGH_C)) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    p_rise_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && !e_q && seen_rise) |-> (since_rise >= MON_W'(CYC_C)));

    p_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_e && e_q) |-> (hi_cnt >= MON_W'(HIGH_C)));

    p_oe_write_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_db_oe |-> !lcd_rw);

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> ($stable(lcd_rs) && $stable(lcd_rw)));

    p_wdata_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && lcd_db_oe) |-> $stable(lcd_db_out));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_accept_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_ignore_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(lcd_rs) && $stable(lcd_rw)));

endmodule

// File: tb/lcd_bus_engine_bench.sv
module lcd_bus_engine_bench;

    localparam int HIGH_EXP = 19;
    localparam int CYC_EXP  = 120;

    // {nibble, rs, rw, wdata[8], rd_drive[8], rd_expect[8]}
    localparam int NVEC = 6;
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 1'b0, 8'hA5, 8'h00, 8'h00},
        {1'b0, 1'b0, 1'b0, 8'h38, 8'h00, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'h00, 8'h3C, 8'h3C},
        {1'b1, 1'b1, 1'b0, 8'h9E, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'hC7, 8'hC7},
        {1'b1, 1'b0, 1'b0, 8'h01, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_rs = 1'b0;
    logic       req_rw = 1'b0;
    logic       req_nibble_mode = 1'b0;
    logic [7:0] req_data = 8'h00;
    logic       busy, done, lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
    logic [7:0] rd_data, lcd_db_out;
    logic [7:0] lcd_db_in = 8'h00;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lcd_bus_engine u_lcd_bus_engine (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_rs          (req_rs),
        .req_rw          (req_rw),
        .req_nibble_mode (req_nibble_mode),
        .req_data        (req_data),
        .busy            (busy),
        .done            (done),
        .rd_data         (rd_data),
        .lcd_rs          (lcd_rs),
        .lcd_rw          (lcd_rw),
        .lcd_e           (lcd_e),
        .lcd_db_out      (lcd_db_out),
        .lcd_db_oe       (lcd_db_oe),
        .lcd_db_in       (lcd_db_in)
    );

    // Bus observer state
    int         pulses, high_cnt, high_len, last_rise, post;
    int         setup_err, stab_err, hold_err, spc_err;
    bit         have_rise, oe_seen, cur_m4, cur_wr;
    logic [7:0] cur_rdv, cap_v;
    logic [7:0] caps [2];
    logic       e_p, rs_p, rw_p, oe_p;
    logic [7:0] db_p;

    initial begin
        pulses = 0; high_cnt = 0; high_len = 0; last_rise = 0; post = 0;
        setup_err = 0; stab_err = 0; hold_err = 0; spc_err = 0;
        have_rise = 0; oe_seen = 0; cur_m4 = 0; cur_wr = 0; cur_rdv = 0;
        cap_v = 0; caps[0] = 0; caps[1] = 0;
        e_p = 0; rs_p = 0; rw_p = 0; oe_p = 0; db_p = 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (lcd_e && !e_p) begin
                pulses = pulses + 1;
                if (have_rise && (cyc - last_rise) < CYC_EXP) spc_err = spc_err + 1;
                last_rise = cyc;
                have_rise = 1;
                if (lcd_rs !== rs_p || lcd_rw !== rw_p) setup_err = setup_err + 1;
                if (lcd_db_oe && (!oe_p || lcd_db_out !== db_p)) setup_err = setup_err + 1;
                high_cnt = 0;
                if (cur_m4) lcd_db_in = (pulses == 1) ? {cur_rdv[7:4], 4'h5} : {cur_rdv[3:0], 4'hA};
                else        lcd_db_in = cur_rdv;
            end
            if (lcd_e) begin
                high_cnt = high_cnt + 1;
                if (e_p && (lcd_rs !== rs_p || lcd_rw !== rw_p)) stab_err = stab_err + 1;
                if (e_p && lcd_db_oe && lcd_db_out !== db_p) stab_err = stab_err + 1;
                cap_v = lcd_db_out;
            end
            if (lcd_db_oe) oe_seen = 1;
            if (!lcd_e && e_p) begin
                high_len = high_cnt;
                if (pulses >= 1 && pulses <= 2) caps[pulses-1] = cap_v;
                post = 2;
            end
            if (post > 0 && !lcd_e) begin
                if (cur_wr && (!lcd_db_oe || lcd_db_out !== cap_v)) hold_err = hold_err + 1;
                post = post - 1;
            end
            e_p = lcd_e; rs_p = lcd_rs; rw_p = lcd_rw; oe_p = lcd_db_oe; db_p = lcd_db_out;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic run(input logic [26:0] v, input bit inject);
        logic m4, rs, rw;
        logic [7:0] wd, rdv, exp;
        int n;
        {m4, rs, rw, wd, rdv, exp} = v;
        @(negedge clk);
        pulses = 0; high_len = 0; setup_err = 0; stab_err = 0; hold_err = 0;
        oe_seen = 0; caps[0] = 8'h00; caps[1] = 8'h00;
        cur_m4 = m4; cur_wr = !rw; cur_rdv = rdv;
        req_valid = 1; req_rs = rs; req_rw = rw; req_nibble_mode = m4; req_data = wd;
        @(negedge clk);
        req_valid = 0;
        chk(busy === 1'b1, "R2 busy after accept", int'(busy), 1);
        if (inject) begin
            repeat (10) @(negedge clk);
            req_valid = 1; req_rs = !rs; req_rw = !rw; req_nibble_mode = !m4; req_data = ~wd;
            @(negedge clk);
            req_valid = 0;
        end
        n = 0;
        while (done !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n = n + 1;
        end
        chk(done === 1'b1, "R11 done reached", int'(done), 1);
        chk(pulses == (m4 ? 2 : 1), m4 ? "R4 pulse count" : "R3 pulse count", pulses, m4 ? 2 : 1);
        chk(high_len == HIGH_EXP, "R5 enable high width", high_len, HIGH_EXP);
        chk(spc_err == 0, "R6 rise spacing violations", spc_err, 0);
        chk(setup_err == 0 && stab_err == 0, "R7 address setup/stability errors",
            setup_err + stab_err, 0);
        chk(lcd_rs === rs && lcd_rw === rw, "R7 address held to done",
            int'({lcd_rs, lcd_rw}), int'({rs, rw}));
        if (rw) begin
            chk(oe_seen == 0, "R9 oe during read", int'(oe_seen), 0);
            chk(rd_data === exp, "R10 read data at done", int'(rd_data), int'(exp));
        end else begin
            chk(oe_seen == 1, "R9 oe during write", int'(oe_seen), 1);
            chk(hold_err == 0, "R8 write data hold errors", hold_err, 0);
            if (m4) begin
                chk(caps[0] === {wd[7:4], 4'h0}, "R4 first nibble", int'(caps[0]), int'({wd[7:4], 4'h0}));
                chk(caps[1] === {wd[3:0], 4'h0}, "R4 second nibble", int'(caps[1]), int'({wd[3:0], 4'h0}));
            end else begin
                chk(caps[0] === wd, "R3 write byte", int'(caps[0]), int'(wd));
            end
        end
        @(negedge clk);
        chk(done === 1'b0, "R11 done single cycle", int'(done), 0);
        chk(busy === 1'b0, "R11 busy falls after done", int'(busy), 0);
    endtask

    initial begin
        #3_000_000;
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(lcd_e === 1'b0 && lcd_db_oe === 1'b0, "R1 strobe/oe in reset",
            int'({lcd_e, lcd_db_oe}), 0);
        rst_n = 1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done after reset", int'({busy, done}), 0);
        chk(rd_data === 8'h00, "R1 rd_data after reset", int'(rd_data), 0);
        chk(lcd_e === 1'b0 && lcd_db_oe === 1'b0, "R1 strobe/oe after reset",
            int'({lcd_e, lcd_db_oe}), 0);

        // Table walk, back to back (R6 spacing across transactions)
        for (int i = 0; i < NVEC; i++) begin
            run(VEC[i], 1'b0);
        end

        // R2: request presented mid-transaction is ignored
        run({1'b0, 1'b1, 1'b0, 8'h5A, 8'h00, 8'h00}, 1'b1);
        // R2 again in nibble mode, then a read that ignores low lines (R10)
        run({1'b1, 1'b0, 1'b0, 8'hE3, 8'h00, 8'h00}, 1'b1);
        run({1'b1, 1'b1, 1'b1, 8'h00, 8'h0F, 8'h0F}, 1'b0);
        run({1'b0, 1'b0, 1'b1, 8'h00, 8'hF0, 8'hF0}, 1'b1);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule